// File: doc/BRIEF.md
# UART Interrupt and Status Controller

This block is the register side of a serial port. It gathers the event sources that a receiver, a transmitter and their 16-entry FIFOs produce, keeps them as pending interrupt bits, masks them with per-source enable bits and drives one registered interrupt line to a processor. Software reaches it through a simple 32-bit memory-mapped register port with a 0x40-byte window. The shift registers, the FIFO storage and the baud generator are outside the block. The block sees them only through counts, strobes and levels.

There are four interrupt sources. A receive source fires on a stored byte once the FIFO count reaches a programmable level. A transmit source fires when the transmit FIFO drains down to its programmable level. A modem source fires on any change of the synchronised CTS input. A receive-timeout source fires when data waits in the receive FIFO and no new byte has arrived for 32 bit-times. Line errors collect in a separate sticky status register. A flag register reports the live FIFO, busy and modem levels.

The interrupt handler reads the identification register, services every bit that is set, and writes any value to that register to clear it. It keeps reading until the register reads zero.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset the control, identification and error status registers read zero, the RX level register (0x38) reads 1, the TX level register (0x3C) reads 0 and `irq` is low.
- R2: The control register at 0x10 stores bit0 UART enable, bit3 modem enable, bit4 receive enable, bit5 transmit enable, bit6 timeout enable and bit7 loopback, and it reads back those bits. Bits 1 and 2 always read as zero.
- R3: Identification bit1 (receive) is set in the cycle after an `rx_push` strobe when `rx_count`+1 is greater than or equal to the RX level. A level of 0 acts as 1, so a level of 1 sets the bit on every received byte.
- R4: Identification bit2 (transmit) is set when `tx_count` goes from above the TX level to at or below it. A count that stays at or below the level does not set the bit again.
- R5: Identification bit0 (modem) is set on every change of the synchronised CTS input, rising or falling.
- R6: Identification bit3 (timeout) is set on the 32nd `bit_tick` counted while `rx_count` is non-zero and no `rx_push` occurs. A push or an empty FIFO restarts the count.
- R7: A pending bit is set only while its own enable bit and control bit0 are both 1. Writing zero to the control register stops all new pending bits and drops `irq`.
- R8: Any write to the identification register (0x1C) clears all four pending bits. An enabled event in the same cycle as the write wins, and its bit stays set.
- R9: `irq` is a register that goes high one cycle after a pending bit is set while the matching enable is 1. Clearing that enable pulls `irq` low but leaves the pending bit set.
- R10: The error status register at 0x04 holds sticky bits: bit0 framing, bit1 parity, bit2 break and bit3 overrun. A write to it clears the bits, and an error strobe in the same cycle as the write wins.
- R11: The flag register at 0x18 reads bit0 CTS, bit1 DSR, bit2 DCD (all synchronised), bit3 busy, bit4 RX empty, bit5 TX full, bit6 RX full and bit7 TX empty. A FIFO is full at a count of 16.
- R12: The RX and TX level registers at 0x38 and 0x3C are 5 bits wide and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_sel` is high |
| rx_push | input | 1 | One-cycle strobe: the receiver stored a byte |
| rx_count | input | 5 | RX FIFO count before this cycle's push |
| tx_count | input | 5 | TX FIFO count |
| tx_busy | input | 1 | Transmitter is shifting |
| bit_tick | input | 1 | One-cycle strobe once per bit-time |
| err_frame | input | 1 | Framing error strobe |
| err_parity | input | 1 | Parity error strobe |
| err_break | input | 1 | Break strobe |
| err_overrun | input | 1 | Overrun strobe |
| cts_in | input | 1 | Asynchronous clear-to-send level |
| dsr_in | input | 1 | Asynchronous data-set-ready level |
| dcd_in | input | 1 | Asynchronous carrier-detect level |
| irq | output | 1 | Registered interrupt request |

## Verification
The flag register is walked through a table of FIFO counts, busy and modem levels. The table includes counts at 0, 15 and 16, so that the empty and full thresholds are checked separately for each FIFO. The receive source is tried at levels 1 and 3, with pushes below, at and above the level. This shows the difference between firing on every byte, firing at the threshold crossing and not firing early. The transmit source gets a count that falls step by step and then sits at the level, which separates edge triggering from level triggering. CTS toggles in both directions, the timeout runs to 31 and then 32 ticks, and clear writes are placed in the same cycle as events, so that the event-wins rule is shown apart from a plain clear.

// File: rtl/uic_pkg.sv
package uic_pkg;

    // register offsets inside the 0x40-byte window
    localparam int OFS_ERR  = 'h04;
    localparam int OFS_CTRL = 'h10;
    localparam int OFS_FLAG = 'h18;
    localparam int OFS_IDR  = 'h1C;
    localparam int OFS_RXLV = 'h38;
    localparam int OFS_TXLV = 'h3C;

    // interrupt source positions in the identification register
    localparam int SRC_N  = 4;
    localparam int SRC_MS = 0;
    localparam int SRC_RX = 1;
    localparam int SRC_TX = 2;
    localparam int SRC_TO = 3;

    typedef struct packed {
        logic       loopback;
        logic       to_ie;
        logic       tx_ie;
        logic       rx_ie;
        logic       ms_ie;
        logic [1:0] rsvd;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic tx_empty;
        logic rx_full;
        logic tx_full;
        logic rx_empty;
        logic busy;
        logic dcd;
        logic dsr;
        logic cts;
    } flags_t;

    typedef struct packed {
        logic overrun;
        logic brk;
        logic parity;
        logic frame;
    } err_t;

    // per-source enables, all forced off while the port is disabled
    function automatic logic [SRC_N-1:0] src_enables(ctrl_t c);
        return c.enable ? {c.to_ie, c.tx_ie, c.rx_ie, c.ms_ie} : '0;
    endfunction

    function automatic ctrl_t ctrl_from_bus(logic [7:0] w);
        ctrl_t c;
        c      = ctrl_t'(w);
        c.rsvd = '0;
        return c;
    endfunction

endpackage

// File: rtl/uic_sync.sv
module uic_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/uic_timeout.sv
module uic_timeout #(
    parameter int TMO_BITS = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rx_push,
    input  logic rx_nonempty,
    output logic tmo_evt
);
    localparam int CW = $clog2(TMO_BITS + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!rx_nonempty || rx_push) begin
            cnt <= '0;
        end else if (bit_tick && cnt < CW'(TMO_BITS)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // one strobe on the tick that completes the quiet window
    assign tmo_evt = rx_nonempty && !rx_push && bit_tick && (cnt == CW'(TMO_BITS - 1));

    assert_tmo_bound_R6: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(TMO_BITS));

    assert_tmo_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_push || !rx_nonempty) |=> cnt == '0);
endmodule

// File: rtl/uic_pending.sv
module uic_pending #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic [N-1:0] en,
    input  logic         clr,
    output logic [N-1:0] pend,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)                 bit_q <= 1'b0;
            else if (ev[i] && en[i]) bit_q <= 1'b1;
            else if (clr)            bit_q <= 1'b0;
        end

        assign pend[i] = bit_q;

        assert_masked_no_set_R7: assert property (@(posedge clk) disable iff (rst)
            (!bit_q && !en[i]) |=> !bit_q);

        assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (ev[i] && en[i]) |=> bit_q);

        assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
            (clr && !(ev[i] && en[i])) |=> !bit_q);
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(pend & en);
    end

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        ((pend & en) == '0) |=> !irq);
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
    import uic_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int TMO_BITS    = 32,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_push,
    input  logic [LVL_W-1:0]  rx_count,
    input  logic [LVL_W-1:0]  tx_count,
    input  logic              tx_busy,
    input  logic              bit_tick,
    input  logic              err_frame,
    input  logic              err_parity,
    input  logic              err_break,
    input  logic              err_overrun,
    input  logic              cts_in,
    input  logic              dsr_in,
    input  logic              dcd_in,
    output logic              irq
);
    ctrl_t             ctrl_q;
    err_t              err_q, err_in;
    logic [LVL_W-1:0]  rx_lvl_q, tx_lvl_q;
    logic [2:0]        modem_s;
    logic              cts_prev, tx_cond_q;
    logic [SRC_N-1:0]  ev, en, pend;
    logic              tmo_evt;
    flags_t            flags;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:8];

    // register write strobes
    logic wr_stb, wr_ctrl, wr_err, wr_idr, wr_rxlv, wr_txlv;
    assign wr_stb  = bus_sel && bus_wr;
    assign wr_ctrl = wr_stb && bus_addr == ADDR_W'(OFS_CTRL);
    assign wr_err  = wr_stb && bus_addr == ADDR_W'(OFS_ERR);
    assign wr_idr  = wr_stb && bus_addr == ADDR_W'(OFS_IDR);
    assign wr_rxlv = wr_stb && bus_addr == ADDR_W'(OFS_RXLV);
    assign wr_txlv = wr_stb && bus_addr == ADDR_W'(OFS_TXLV);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            rx_lvl_q <= LVL_W'(1);
            tx_lvl_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q   <= ctrl_from_bus(bus_wdata[7:0]);
            if (wr_rxlv) rx_lvl_q <= bus_wdata[LVL_W-1:0];
            if (wr_txlv) tx_lvl_q <= bus_wdata[LVL_W-1:0];
        end
    end

    // sticky line errors; a strobe beats a clearing write
    assign err_in = '{overrun: err_overrun, brk: err_break, parity: err_parity, frame: err_frame};

    always_ff @(posedge clk) begin
        if (rst) err_q <= '0;
        else     err_q <= (wr_err ? err_t'('0) : err_q) | err_in;
    end

    // modem inputs: {dcd, dsr, cts}
    uic_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({dcd_in, dsr_in, cts_in}),
        .q   (modem_s)
    );

    // receive source: count after the push reaches the level (0 counts as 1)
    logic [LVL_W:0] rx_after, rx_thr;
    assign rx_after = {1'b0, rx_count} + (LVL_W+1)'(1);
    assign rx_thr   = (rx_lvl_q == '0) ? (LVL_W+1)'(1) : {1'b0, rx_lvl_q};

    // transmit source: count falls to the level
    logic tx_cond;
    assign tx_cond = tx_count <= tx_lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cts_prev  <= 1'b0;
            tx_cond_q <= 1'b0;
        end else begin
            cts_prev  <= modem_s[0];
            tx_cond_q <= tx_cond;
        end
    end

    uic_timeout #(.TMO_BITS(TMO_BITS)) u_tmo (
        .clk         (clk),
        .rst         (rst),
        .bit_tick    (bit_tick),
        .rx_push     (rx_push),
        .rx_nonempty (rx_count != '0),
        .tmo_evt     (tmo_evt)
    );

    assign ev[SRC_MS] = modem_s[0] ^ cts_prev;
    assign ev[SRC_RX] = rx_push && (rx_after >= rx_thr);
    assign ev[SRC_TX] = tx_cond && !tx_cond_q;
    assign ev[SRC_TO] = tmo_evt;
    assign en         = src_enables(ctrl_q);

    uic_pending #(.N(SRC_N)) u_pend (
        .clk  (clk),
        .rst  (rst),
        .ev   (ev),
        .en   (en),
        .clr  (wr_idr),
        .pend (pend),
        .irq  (irq)
    );

    // live flags
    always_comb begin
        flags          = '0;
        flags.cts      = modem_s[0];
        flags.dsr      = modem_s[1];
        flags.dcd      = modem_s[2];
        flags.busy     = tx_busy;
        flags.rx_empty = rx_count == '0;
        flags.tx_full  = tx_count == LVL_W'(DEPTH);
        flags.rx_full  = rx_count == LVL_W'(DEPTH);
        flags.tx_empty = tx_count == '0;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADDR_W'(OFS_ERR):  bus_rdata = DATA_W'(err_q);
                ADDR_W'(OFS_CTRL): bus_rdata = DATA_W'(ctrl_q);
                ADDR_W'(OFS_FLAG): bus_rdata = DATA_W'(flags);
                ADDR_W'(OFS_IDR):  bus_rdata = DATA_W'(pend);
                ADDR_W'(OFS_RXLV): bus_rdata = DATA_W'(rx_lvl_q);
                ADDR_W'(OFS_TXLV): bus_rdata = DATA_W'(tx_lvl_q);
                default:           bus_rdata = '0;
            endcase
        end
    end

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !wr_err |=> ((err_q & $past(err_q)) == $past(err_q)));

    assert_err_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_err && err_in == '0) |=> err_q == '0);

    assert_ctrl_rsvd_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rsvd == '0);

    assert_off_no_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.enable && !$past(ctrl_q.enable)) |-> !irq);
endmodule

// File: tb/sim_uart_evt_ctrl.sv
`timescale 1ns/1ps
module sim_uart_evt_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_push = 1'b0;
    logic [4:0]  rx_count = '0, tx_count = '0;
    logic        tx_busy = 1'b0, bit_tick = 1'b0;
    logic        err_frame = 1'b0, err_parity = 1'b0, err_break = 1'b0, err_overrun = 1'b0;
    logic        cts_in = 1'b0, dsr_in = 1'b0, dcd_in = 1'b0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    uart_evt_ctrl u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_push(rx_push), .rx_count(rx_count),
        .tx_count(tx_count), .tx_busy(tx_busy), .bit_tick(bit_tick), .err_frame(err_frame),
        .err_parity(err_parity), .err_break(err_break), .err_overrun(err_overrun),
        .cts_in(cts_in), .dsr_in(dsr_in), .dcd_in(dcd_in), .irq(irq)
    );

    // flag-register vectors: counts, busy, cts, dsr, dcd -> expected flags
    typedef struct packed {
        logic [4:0] rxc;
        logic [4:0] txc;
        logic       busy;
        logic       cts;
        logic       dsr;
        logic       dcd;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{5'd0,  5'd0,  1'b0, 1'b0, 1'b0, 1'b0, 8'h90},
        '{5'd16, 5'd16, 1'b1, 1'b1, 1'b0, 1'b0, 8'h69},
        '{5'd3,  5'd0,  1'b1, 1'b0, 1'b1, 1'b0, 8'h8A},
        '{5'd0,  5'd16, 1'b0, 1'b1, 1'b0, 1'b1, 8'h35},
        '{5'd15, 5'd15, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
        '{5'd16, 5'd0,  1'b0, 1'b0, 1'b1, 1'b1, 8'hC6}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic push();
        @(negedge clk);
        rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
        rx_count = rx_count + 1'b1;
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic errs(input logic [3:0] e);
        @(negedge clk);
        {err_overrun, err_break, err_parity, err_frame} = e;
        @(negedge clk);
        {err_overrun, err_break, err_parity, err_frame} = '0;
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(6'h10, d); check("R1 ctrl", d, 32'h0);
        rd(6'h1C, d); check("R1 id", d, 32'h0);
        rd(6'h04, d); check("R1 status", d, 32'h0);
        rd(6'h38, d); check("R1 rx level", d, 32'h1);
        rd(6'h3C, d); check("R1 tx level", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R11 flag table
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            rx_count = TBL[i].rxc; tx_count = TBL[i].txc; tx_busy = TBL[i].busy;
            cts_in = TBL[i].cts; dsr_in = TBL[i].dsr; dcd_in = TBL[i].dcd;
            step(4);
            rd(6'h18, d); check($sformatf("R11 flags vec%0d", i), d, {24'b0, TBL[i].exp});
        end
        @(negedge clk);
        rx_count = '0; tx_count = '0; tx_busy = 1'b0;
        step(4);

        // R2 control bits
        wr(6'h10, 32'hFF);
        rd(6'h10, d); check("R2 ctrl readback", d, 32'hF9);
        wr(6'h10, 32'h0);
        wr(6'h1C, 32'h0);

        // R7: no pending while disabled, or with enable bit but port off
        push();
        rd(6'h1C, d); check("R7 off no pend", d, 32'h0);
        wr(6'h10, 32'h10);
        push();
        rd(6'h1C, d); check("R7 port off no pend", d, 32'h0);

        // R3 receive at level 1, every byte
        wr(6'h10, 32'h11);
        @(negedge clk); rx_count = '0;
        push();
        rd(6'h1C, d); check("R3 first byte", d, 32'h2);
        check("R9 irq one cycle later", {31'b0, irq}, 32'h0);
        step(1);
        check("R9 irq high", {31'b0, irq}, 32'h1);
        wr(6'h1C, 32'h1234);
        rd(6'h1C, d); check("R8 clear", d, 32'h0);
        step(1);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        push();
        rd(6'h1C, d); check("R3 second byte", d, 32'h2);
        wr(6'h1C, 32'h0);

        // R3 level 3
        wr(6'h38, 32'h3);
        @(negedge clk); rx_count = '0;
        push();
        push();
        rd(6'h1C, d); check("R3 below level", d, 32'h0);
        push();
        rd(6'h1C, d); check("R3 at level", d, 32'h2);
        wr(6'h1C, 32'h0);
        wr(6'h38, 32'h1);

        // R8 same-cycle clear and event
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h0;
        rx_push = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; rx_push = 1'b0; rx_count = rx_count + 1'b1;
        rd(6'h1C, d); check("R8 event wins", d, 32'h2);

        // R9 masking by enable keeps pending
        step(1);
        check("R9 irq before mask", {31'b0, irq}, 32'h1);
        wr(6'h10, 32'h01);
        step(1);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        rd(6'h1C, d); check("R9 pending kept", d, 32'h2);
        wr(6'h10, 32'h11);
        step(1);
        check("R9 irq unmasked", {31'b0, irq}, 32'h1);

        // R4 transmit threshold edge
        wr(6'h10, 32'h21);
        wr(6'h3C, 32'h2);
        @(negedge clk); tx_count = 5'd5;
        step(2);
        wr(6'h1C, 32'h0);
        @(negedge clk); tx_count = 5'd3;
        step(2);
        rd(6'h1C, d); check("R4 above level", d, 32'h0);
        @(negedge clk); tx_count = 5'd2;
        step(2);
        rd(6'h1C, d); check("R4 reach level", d, 32'h4);
        wr(6'h1C, 32'h0);
        step(3);
        rd(6'h1C, d); check("R4 no retrigger", d, 32'h0);

        // R5 CTS change both ways
        wr(6'h10, 32'h09);
        wr(6'h1C, 32'h0);
        @(negedge clk); cts_in = 1'b1;
        step(5);
        rd(6'h1C, d); check("R5 cts rise", d, 32'h1);
        wr(6'h1C, 32'h0);
        step(2);
        rd(6'h1C, d); check("R5 steady", d, 32'h0);
        @(negedge clk); cts_in = 1'b0;
        step(5);
        rd(6'h1C, d); check("R5 cts fall", d, 32'h1);

        // R7 write zero to control drops irq and blocks sources
        check("R7 irq before off", {31'b0, irq}, 32'h1);
        wr(6'h10, 32'h0);
        step(1);
        check("R7 irq after off", {31'b0, irq}, 32'h0);
        wr(6'h1C, 32'h0);
        @(negedge clk); cts_in = 1'b1;
        step(5);
        rd(6'h1C, d); check("R7 off cts ignored", d, 32'h0);

        // R6 receive timeout window
        wr(6'h10, 32'h41);
        wr(6'h1C, 32'h0);
        push();
        tick(31);
        rd(6'h1C, d); check("R6 31 ticks", d, 32'h0);
        tick(1);
        rd(6'h1C, d); check("R6 32 ticks", d, 32'h8);
        wr(6'h1C, 32'h0);
        tick(5);
        rd(6'h1C, d); check("R6 saturated", d, 32'h0);

        // R10 error status
        errs(4'b0010);
        rd(6'h04, d); check("R10 parity", d, 32'h2);
        errs(4'b1001);
        rd(6'h04, d); check("R10 sticky", d, 32'hB);
        wr(6'h04, 32'h0);
        rd(6'h04, d); check("R10 clear", d, 32'h0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h04; err_break = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; err_break = 1'b0;
        rd(6'h04, d); check("R10 error wins", d, 32'h4);

        // R12 level registers
        wr(6'h38, 32'h10);
        rd(6'h38, d); check("R12 rx level", d, 32'h10);
        wr(6'h3C, 32'h7);
        rd(6'h3C, d); check("R12 tx level", d, 32'h7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule